// File: doc/BRIEF.md
# Branch Decision and Next-Address Unit

This is a purely combinational unit for the execute stage of a 32-bit core. Each cycle it receives:

- the current program counter and the sequential address chosen by the caller;
- a branch-kind code;
- two register operands and the carry flag;
- a raw displacement field, with a select that says how many of its low bits are meaningful.

From these it decides whether control transfers. It then produces the following address, either the branch target or the sequential address. For the call form, it also produces the write of the return address into the link register.

The displacement counts words. The unit sign-extends it and multiplies it by four before adding it to the current PC. The addition wraps at 32 bits. Fetch, the register file, flushing and the carry flag itself are outside the unit, and the unit never drives the carry flag.

Top module: `brnpc_unit`

## Requirements
- R1: Kind code 0 (no branch) and the unused codes 13, 14 and 15 give taken=0, link_we=0 and next_pc=seq_pc.
- R2: The displacement select picks the field and sign-extends it to 32 bits: 0 uses disp_raw[7:0], 1 uses disp_raw[15:0], and 2 or 3 use disp_raw[23:0]. The target is cur_pc + (extended value << 2).
- R3: Kind code 1 (unconditional) is always taken, and next_pc is the target.
- R4: Kind code 3 is taken when carry_in is 1. Kind code 4 is taken when carry_in is 0.
- R5: Kind code 5 is taken when opa equals opb. Kind code 6 is taken when they differ.
- R6: Kind codes 7 to 12 test opa as a signed value against zero, in this order: ==0, !=0, >=0, >0, <=0, <0.
- R7: Kind code 2 (call) is always taken. It asserts link_we, drives link_idx=14 and drives link_data=cur_pc+4.
- R8: link_we is 1 only for kind code 2.
- R9: Whenever taken is 0, next_pc equals seq_pc.
- R10: Both the target sum and the return address wrap modulo 2^32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cur_pc | input | 32 | Address of the current instruction |
| seq_pc | input | 32 | Fall-through address chosen by the caller |
| br_kind | input | 4 | Branch kind code |
| opa | input | 32 | First register operand |
| opb | input | 32 | Second register operand |
| carry_in | input | 1 | Current carry flag |
| disp_raw | input | 24 | Raw displacement field, in words |
| disp_sel | input | 2 | Displacement width select |
| next_pc | output | 32 | Address of the following instruction |
| taken | output | 1 | Control transfer decided |
| link_we | output | 1 | Link register write enable |
| link_idx | output | 4 | Link register index |
| link_data | output | 32 | Return address to write |

## Verification
The embedded assertions are evaluated whenever the inputs change. They cover four properties:

- a link write appears only for the call kind, and it is always taken;
- a not-taken decision always yields the sequential address;
- the no-branch and unused codes never transfer control;
- a taken branch keeps the low two address bits of the current PC.

Only the bench's sweeps can show that each condition decides correctly over signed edge operands and both carry values. The same holds for sign extension at each field width and for wrap-around near both ends of the address space. The bench compares every output against values it computes arithmetically.

// File: rtl/brnpc_unit.sv
module brnpc_unit #(
  parameter int W        = 32,
  parameter int DW       = 24,
  parameter int SHAMT    = 2,
  parameter int RW       = 4,
  parameter int LINK_REG = 14,
  parameter int LINK_OFS = 4
) (
  input  logic [W-1:0]  cur_pc,
  input  logic [W-1:0]  seq_pc,
  input  logic [3:0]    br_kind,
  input  logic [W-1:0]  opa,
  input  logic [W-1:0]  opb,
  input  logic          carry_in,
  input  logic [DW-1:0] disp_raw,
  input  logic [1:0]    disp_sel,
  output logic [W-1:0]  next_pc,
  output logic          taken,
  output logic          link_we,
  output logic [RW-1:0] link_idx,
  output logic [W-1:0]  link_data
);
  localparam int HW = DW / 3;
  localparam int MW = 2 * HW;
  localparam logic [3:0] K_NONE = 4'd0,  K_ALW = 4'd1,  K_LINK = 4'd2,  K_C   = 4'd3;
  localparam logic [3:0] K_NC   = 4'd4,  K_EQ  = 4'd5,  K_NE   = 4'd6,  K_EQZ = 4'd7;
  localparam logic [3:0] K_NEZ  = 4'd8,  K_GEZ = 4'd9,  K_GTZ  = 4'd10, K_LEZ = 4'd11;
  localparam logic [3:0] K_LTZ  = 4'd12;

  logic [W-1:0] disp_ext, offset, target;
  logic a_zero, a_neg, cond;

  always_comb begin
    case (disp_sel)
      2'd0:    disp_ext = {{(W-HW){disp_raw[HW-1]}}, disp_raw[HW-1:0]};
      2'd1:    disp_ext = {{(W-MW){disp_raw[MW-1]}}, disp_raw[MW-1:0]};
      default: disp_ext = {{(W-DW){disp_raw[DW-1]}}, disp_raw};
    endcase
  end

  assign offset = disp_ext << SHAMT;
  assign target = cur_pc + offset;
  assign a_zero = (opa == '0);
  assign a_neg  = opa[W-1];

  always_comb begin
    case (br_kind)
      K_ALW, K_LINK: cond = 1'b1;
      K_C:   cond = carry_in;
      K_NC:  cond = !carry_in;
      K_EQ:  cond = (opa == opb);
      K_NE:  cond = (opa != opb);
      K_EQZ: cond = a_zero;
      K_NEZ: cond = !a_zero;
      K_GEZ: cond = !a_neg;
      K_GTZ: cond = !a_neg && !a_zero;
      K_LEZ: cond = a_neg || a_zero;
      K_LTZ: cond = a_neg;
      default: cond = 1'b0;
    endcase
  end

  assign taken     = cond;
  assign next_pc   = cond ? target : seq_pc;
  assign link_we   = (br_kind == K_LINK);
  assign link_idx  = RW'(LINK_REG);
  assign link_data = cur_pc + W'(LINK_OFS);

  always_comb begin
    AST_LINK_ONLY_CALL: assert (!link_we || br_kind == K_LINK) else $error("link write outside call"); // R8
    AST_LINK_IS_TAKEN: assert (!link_we || taken) else $error("call not taken"); // R7
    AST_FALLTHROUGH_SEQ: assert (taken || next_pc == seq_pc) else $error("not taken but next_pc moved"); // R9
    AST_IDLE_NEVER_TAKEN: assert (!(br_kind == K_NONE || br_kind > K_LTZ) || !taken) else $error("idle code taken"); // R1
    AST_TARGET_ALIGNED: assert (!taken || next_pc[SHAMT-1:0] == cur_pc[SHAMT-1:0]) else $error("target misaligned"); // R2
  end
endmodule

// File: tb/brnpc_unit_tb.sv
module brnpc_unit_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic [31:0] cur_pc, seq_pc, opa, opb, next_pc, link_data;
  logic [3:0]  br_kind, link_idx;
  logic        carry_in, taken, link_we;
  logic [23:0] disp_raw;
  logic [1:0]  disp_sel;
  int checks = 0;
  int errors = 0;
  logic [31:0] vals [6];

  brnpc_unit u_dut (
    .cur_pc(cur_pc), .seq_pc(seq_pc), .br_kind(br_kind), .opa(opa), .opb(opb),
    .carry_in(carry_in), .disp_raw(disp_raw), .disp_sel(disp_sel),
    .next_pc(next_pc), .taken(taken), .link_we(link_we), .link_idx(link_idx),
    .link_data(link_data)
  );

  function automatic bit exp_take(int k, logic [31:0] a, logic [31:0] b, bit c);
    case (k)
      1, 2: return 1'b1;
      3:  return c;
      4:  return !c;
      5:  return a == b;
      6:  return a != b;
      7:  return $signed(a) == 0;
      8:  return $signed(a) != 0;
      9:  return $signed(a) >= 0;
      10: return $signed(a) > 0;
      11: return $signed(a) <= 0;
      12: return $signed(a) < 0;
      default: return 1'b0;
    endcase
  endfunction

  function automatic string tag_of(int k);
    case (k)
      1: return "R3";
      2: return "R7";
      3, 4: return "R4";
      5, 6: return "R5";
      7, 8, 9, 10, 11, 12: return "R6";
      default: return "R1";
    endcase
  endfunction

  function automatic longint disp_words(int sel, logic [23:0] raw);
    if (sel == 0) return longint'($signed(raw[7:0]));
    if (sel == 1) return longint'($signed(raw[15:0]));
    return longint'($signed(raw));
  endfunction

  task automatic apply(int k, logic [31:0] pc, logic [31:0] sq, logic [31:0] a, logic [31:0] b,
                       bit c, logic [23:0] d, int sel, string tag);
    logic [31:0] e_next;
    bit e_take, e_link, bad;
    @(posedge clk);
    br_kind = 4'(k); cur_pc = pc; seq_pc = sq; opa = a; opb = b;
    carry_in = c; disp_raw = d; disp_sel = 2'(sel);
    @(negedge clk);
    e_take = exp_take(k, a, b, c);
    e_link = (k == 2);
    e_next = e_take ? 32'(longint'(pc) + disp_words(sel, d) * 4) : sq;
    bad = (taken !== e_take) || (next_pc !== e_next) || (link_we !== e_link);
    if (e_link && (link_idx !== 4'd14 || link_data !== pc + 32'd4)) bad = 1'b1;
    checks++;
    if (bad) begin
      errors++;
      $display("FAIL %s kind=%0d: got next=%h tk=%b lw=%b li=%0d ld=%h exp next=%h tk=%b lw=%b ld=%h",
               tag, k, next_pc, taken, link_we, link_idx, link_data, e_next, e_take, e_link, pc + 32'd4);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    vals[0] = 32'h0000_0000; vals[1] = 32'h0000_0001; vals[2] = 32'hFFFF_FFFF;
    vals[3] = 32'h7FFF_FFFF; vals[4] = 32'h8000_0000; vals[5] = 32'h0000_0005;
    br_kind = '0; cur_pc = '0; seq_pc = '0; opa = '0; opb = '0;
    carry_in = 1'b0; disp_raw = '0; disp_sel = '0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // R1 R9: idle state after reset
    apply(0, 32'h0, 32'h4, 32'h0, 32'h0, 1'b0, 24'h0, 0, "R1");
    // R1 R3-R9: every kind code against signed edge operand pairs and both carry values
    for (int k = 0; k < 16; k++)
      for (int i = 0; i < 6; i++)
        for (int j = 0; j < 6; j++)
          for (int c = 0; c < 2; c++)
            apply(k, 32'h0000_1000, 32'h0000_1004, vals[i], vals[j], 1'(c),
                  24'h00_0010, 0, tag_of(k));
    // R2 R10: every 8-bit displacement, near the top and bottom of the space
    for (int d = 0; d < 256; d++)
      apply(1, (d % 2 == 0) ? 32'hFFFF_FF00 : 32'h0000_0040, 32'h0, 32'h0, 32'h0, 1'b0,
            24'hAB_CD00 | 24'(d), 0, "R2");
    // R2 R10: stepped 16-bit displacements, upper field bits set to catch wrong extension
    for (int d = 0; d < 65536; d += 251)
      apply(1, 32'h0001_0000, 32'h0, 32'h0, 32'h0, 1'b0, 24'h7F_0000 | 24'(d), 1, "R2");
    // R2 R10: stepped 24-bit displacements with both select codes 2 and 3
    for (int d = 0; d < 16777216; d += 65521)
      apply(1, 32'hFFFF_FFFC, 32'h0, 32'h0, 32'h0, 1'b0, 24'(d), 2 + (d % 2), "R2");
    // R2: field extremes
    apply(1, 32'h8000_0000, 32'h0, 32'h0, 32'h0, 1'b0, 24'h80_0000, 2, "R2");
    apply(1, 32'h7FFF_FFFC, 32'h0, 32'h0, 32'h0, 1'b0, 24'h7F_FFFF, 3, "R2");
    apply(1, 32'h0, 32'h0, 32'h0, 32'h0, 1'b0, 24'hFF_8000, 1, "R2");
    // R7 R10: return address wraps
    apply(2, 32'hFFFF_FFFC, 32'h0, 32'h0, 32'h0, 1'b0, 24'h00_0001, 0, "R7");
    apply(2, 32'hFFFF_FFF8, 32'h0, 32'h0, 32'h0, 1'b1, 24'hFF_FFFF, 2, "R10");
    // R8 R9: non-call kinds with a wide displacement never link and fall through when false
    apply(5, 32'h100, 32'h2468, 32'h1, 32'h2, 1'b1, 24'h12_3456, 2, "R9");
    apply(4, 32'h100, 32'h1357, 32'h0, 32'h0, 1'b1, 24'h12_3456, 2, "R8");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule